// File: doc/BRIEF.md
# Load-use hazard stall controller

This block sits beside the decode stage of an in-order five-stage pipeline. It catches the one dependence that result bypassing cannot hide: a load in the execute stage whose destination register is a source of the instruction now in decode. Loaded data only exists at the end of the memory stage, so the consumer must wait one cycle.

When the hazard is present in a cycle, the block drops the program-counter write enable and the IF/ID write enable in that same cycle, so fetch and decode keep their contents. It also raises a bubble signal that the surrounding pipeline uses to force the control bits entering execute to a no-op. On the next cycle the load has moved on to the memory stage, the execute slot holds the bubble, and the condition clears without any extra action. A consumer that sits two or more slots behind the load is left to the bypass network and is never stalled.

The decode stage gives a 3-bit operation class. From that class the block works out which source fields the instruction actually reads, so an unused field that happens to match causes no stall.

Top module: `load_use_stall_ctrl`

## Requirements
- R1: The block stalls when `ex_is_load` is 1, `ex_rd` is nonzero, `ex_rd` equals `id_rs1`, and the class reads its first source. Classes 1 (register-register ALU), 2 (ALU with immediate), 3 (load), 4 (store) and 5 (branch) read the first source.
- R2: The block stalls when `ex_is_load` is 1, `ex_rd` is nonzero, `ex_rd` equals `id_rs2`, and the class reads its second source. Only classes 1, 4 and 5 read the second source.
- R3: A load whose destination is register 0 never causes a stall.
- R4: A non-load in execute (`ex_is_load` = 0) never causes a stall, whatever the register fields hold.
- R5: A source field that the class does not read has no effect. Classes 0 (none), 6 (jump) and 7 (reserved) read neither field. Classes 2 and 3 do not read the second field.
- R6: In a stall cycle, `bubble` is 1 and both `pc_we` and `ifid_we` are 0, in that same cycle. There is no register delay.
- R7: When there is no hazard, `bubble` is 0 and both `pc_we` and `ifid_we` are 1.
- R8: A stall lasts one cycle. Once execute holds the inserted bubble while decode still holds the consumer, the outputs return to the run state. A consumer two slots behind the load sees no stall.
- R9: While `rst_n` is 0, `bubble` is 0 and both write enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the property checks |
| rst_n | input | 1 | Active-low reset |
| ex_is_load | input | 1 | The instruction in execute is a load |
| ex_rd | input | 5 | Destination register of the instruction in execute |
| id_kind | input | 3 | Operation class of the instruction in decode |
| id_rs1 | input | 5 | First source field in decode |
| id_rs2 | input | 5 | Second source field in decode |
| pc_we | output | 1 | Program-counter write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| bubble | output | 1 | Force the control bits entering execute to a no-op |

## Verification
Both source comparisons can hit in the same cycle. This happens when a register-register, store or branch instruction names the load's destination in both fields. The bench provokes it with equal `id_rs1`/`id_rs2` behind a load and requires exactly one stall cycle, the same outcome as a single hit. A second overlap is between the zero-register exclusion and a double match: a load to register 0 with both sources at 0 must produce no stall. The release is checked by stepping a small pipeline model through the stall and the bubble cycle.

// File: rtl/lus_pkg.sv
package lus_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_ALU_RR  = 3'd1,
        K_ALU_IMM = 3'd2,
        K_LOAD    = 3'd3,
        K_STORE   = 3'd4,
        K_BRANCH  = 3'd5,
        K_JUMP    = 3'd6,
        K_RSVD    = 3'd7
    } op_kind_e;

    localparam int unsigned N_SRC = 2;

    typedef struct packed {
        logic stall;
        logic pc_we;
        logic ifid_we;
        logic bubble;
    } ctl_t;

endpackage

// File: rtl/lus_operand_use.sv
module lus_operand_use
    import lus_pkg::*;
(
    input  op_kind_e         kind,
    output logic [N_SRC-1:0] uses
);
    always_comb begin
        uses = '0;
        case (kind)
            K_ALU_RR, K_STORE, K_BRANCH: uses = 2'b11;
            K_ALU_IMM, K_LOAD:           uses = 2'b01;
            default:                     uses = 2'b00;
        endcase
    end
endmodule

// File: rtl/lus_src_match.sv
module lus_src_match #(
    parameter int unsigned AW   = 5,
    parameter int unsigned NSRC = 2
) (
    input  logic [AW-1:0]           dst,
    input  logic [NSRC-1:0][AW-1:0] src,
    input  logic [NSRC-1:0]         used,
    output logic [NSRC-1:0]         hit
);
    logic dst_live;
    assign dst_live = |dst;

    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign hit[g] = used[g] && dst_live && (src[g] == dst);
    end
endmodule

// File: rtl/load_use_stall_ctrl.sv
module load_use_stall_ctrl
    import lus_pkg::*;
#(
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic [2:0]        id_kind,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble
);
    op_kind_e                       kind_s;
    logic [N_SRC-1:0]               uses_s;
    logic [N_SRC-1:0]               hit_s;
    logic [N_SRC-1:0][REG_AW-1:0]   src_s;
    ctl_t                           ctl_d;

    assign kind_s = op_kind_e'(id_kind);
    assign src_s  = {id_rs2, id_rs1};

    lus_operand_use i_use (
        .kind (kind_s),
        .uses (uses_s)
    );

    lus_src_match #(.AW(REG_AW), .NSRC(N_SRC)) i_match (
        .dst  (ex_rd),
        .src  (src_s),
        .used (uses_s),
        .hit  (hit_s)
    );

    always_comb begin
        ctl_d         = '0;
        ctl_d.stall   = rst_n && ex_is_load && (|hit_s);
        ctl_d.bubble  = ctl_d.stall;
        ctl_d.pc_we   = !ctl_d.stall;
        ctl_d.ifid_we = !ctl_d.stall;
    end

    assign pc_we   = ctl_d.pc_we;
    assign ifid_we = ctl_d.ifid_we;
    assign bubble  = ctl_d.bubble;

    p_rs1_hazard_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_rd != '0 && ex_rd == id_rs1 &&
         id_kind inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}) |-> bubble);

    p_rs2_hazard_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_rd != '0 && ex_rd == id_rs2 &&
         id_kind inside {3'd1, 3'd4, 3'd5}) |-> bubble);

    p_zero_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !bubble);

    p_nonload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !bubble);

    p_unread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_kind inside {3'd0, 3'd6, 3'd7}) |-> !bubble);

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (!pc_we && !ifid_we));

    p_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |-> (pc_we && ifid_we));

endmodule

// File: tb/test_load_use_stall_ctrl.sv
module test_load_use_stall_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ex_is_load = 1'b0;
    logic [4:0] ex_rd = '0;
    logic [2:0] id_kind = '0;
    logic [4:0] id_rs1 = '0;
    logic [4:0] id_rs2 = '0;
    logic       pc_we, ifid_we, bubble;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    load_use_stall_ctrl i_load_use_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
        .id_kind(id_kind), .id_rs1(id_rs1), .id_rs2(id_rs2),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
    );

    typedef struct packed {
        logic       ld;
        logic [4:0] rd;
        logic [2:0] kind;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic       stall;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'd5,  3'd1, 5'd5,  5'd0,  1'b1, 4'd1},  // R1 rr via rs1
        '{1'b1, 5'd7,  3'd1, 5'd3,  5'd7,  1'b1, 4'd2},  // R2 rr via rs2
        '{1'b1, 5'd9,  3'd1, 5'd9,  5'd9,  1'b1, 4'd2},  // R2 both fields hit
        '{1'b1, 5'd0,  3'd1, 5'd0,  5'd0,  1'b0, 4'd3},  // R3 zero dest
        '{1'b0, 5'd5,  3'd1, 5'd5,  5'd5,  1'b0, 4'd4},  // R4 alu producer
        '{1'b1, 5'd6,  3'd2, 5'd3,  5'd6,  1'b0, 4'd5},  // R5 imm ignores rs2
        '{1'b1, 5'd6,  3'd2, 5'd6,  5'd1,  1'b1, 4'd1},  // R1 imm rs1
        '{1'b1, 5'd4,  3'd4, 5'd2,  5'd4,  1'b1, 4'd2},  // R2 store data
        '{1'b1, 5'd4,  3'd6, 5'd4,  5'd4,  1'b0, 4'd5},  // R5 jump
        '{1'b1, 5'd4,  3'd0, 5'd4,  5'd4,  1'b0, 4'd5},  // R5 none
        '{1'b1, 5'd31, 3'd3, 5'd31, 5'd31, 1'b1, 4'd1},  // R1 load address
        '{1'b1, 5'd8,  3'd3, 5'd2,  5'd8,  1'b0, 4'd5},  // R5 load ignores rs2
        '{1'b1, 5'd12, 3'd5, 5'd1,  5'd12, 1'b1, 4'd2},  // R2 branch
        '{1'b1, 5'd3,  3'd1, 5'd4,  5'd5,  1'b0, 4'd7},  // R7 no match
        '{1'b1, 5'd3,  3'd7, 5'd3,  5'd3,  1'b0, 4'd5}   // R5 reserved
    };

    task automatic check(input string tag, input logic exp_stall);
        logic [2:0] got, exp;
        got = {bubble, pc_we, ifid_we};
        exp = {exp_stall, !exp_stall, !exp_stall};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: {bubble,pc_we,ifid_we} actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic [4:0] rd, input logic [2:0] k,
                         input logic [4:0] a, input logic [4:0] b);
        @(negedge clk);
        ex_is_load = ld; ex_rd = rd; id_kind = k; id_rs1 = a; id_rs2 = b;
        #1;
    endtask

    initial begin
        // R9 reset state with hazard inputs present
        drive(1'b1, 5'd5, 3'd1, 5'd5, 5'd5);
        check("R9 reset", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ld, VECS[i].rd, VECS[i].kind, VECS[i].rs1, VECS[i].rs2);
            check($sformatf("R%0d/R6/R7 vec%0d", VECS[i].req, i), VECS[i].stall);
        end

        // R8: load x5 then dependent add, modelled cycle by cycle
        drive(1'b1, 5'd5, 3'd1, 5'd5, 5'd2);
        check("R8 stall cycle", 1'b1);
        drive(1'b0, 5'd0, 3'd1, 5'd5, 5'd2);   // bubble in EX, ID held
        check("R8 release after bubble", 1'b0);
        drive(1'b0, 5'd6, 3'd1, 5'd5, 5'd5);   // consumer two slots behind
        check("R8 two-slot consumer", 1'b0);
        drive(1'b1, 5'd0, 3'd4, 5'd0, 5'd0);   // R3 double zero match
        check("R3 zero dest store", 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule